// File: doc/BRIEF.md
# Configuration Integrity Checker

This block confirms that a device's configuration memory holds sane contents before the rest of the chip starts normal work. After a start request it reads bytes through a synchronous read port: the address and enable go out in one cycle, and the byte comes back in the next. The block then runs two checks in a fixed order.

The first check is an identification check. Five ASCII digits are read from every second address. Each digit is converted to its numeric value, and the values are added. The total is compared with a 16-bit reference word supplied on an input. One reference value is accepted straight away, with no reads at all.

The second check covers two separate regions. Each region is summed and compared with its own constant. The second region is read only once the first region has matched. Each check has a bounded number of attempts. When a check runs out of attempts, the block raises a recovery request for one cycle, presents a fixed argument with it, and moves on. When the sequence ends, the block gives a pass flag for each check, a sticky failure flag and a one-cycle done pulse.

Top module: `cfg_integrity_chk`

## Requirements
- R1: While reset is held and directly after it, busy_o, done_o, rd_en_o, recover_o, id_pass_o, blk_pass_o and fail_o are all 0.
- R2: A start_i pulse while idle clears the three result flags and raises busy_o in the next cycle. A start_i pulse while busy_o is high has no effect: no extra reads are made, no second done is produced, and the results do not change.
- R3: If ref_i equals 16'h021C, the identification check passes and none of its addresses are read.
- R4: Otherwise the identification check reads addresses 0x0A, 0x0C, 0x0E, 0x10 and 0x12 in that order. It subtracts 0x30 from each byte and passes when the 16-bit sum equals ref_i.
- R5: The block check first reads addresses 0x06 through 0x29 in ascending order. That region passes when its 16-bit byte sum equals 16'h0706.
- R6: Addresses 0x2C through 0x4F are read in ascending order only after the first region has passed. blk_pass_o requires this second sum to equal 16'h0686 as well. A failed attempt restarts the block check at address 0x06.
- R7: Each check is attempted at most TRIES times, 20 by default. When the last attempt of a check fails, the block sets fail_o and pulses recover_o for one cycle with recover_arg_o equal to 100. The sequence then goes on to the next check, or ends if there is none.
- R8: rd_en_o is never high in two consecutive cycles. Each byte costs one issue cycle and one capture cycle, and the data is taken one cycle after its address.
- R9: done_o is a one-cycle pulse in the first cycle in which busy_o is low again. The three result flags hold their values until the next accepted start.
- R10: Every sum is 16 bits wide and wraps modulo 65536. This includes identification bytes below 0x30, whose terms then become negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, acted on only while idle |
| ref_i | input | 16 | Reference word for the identification check |
| rd_en_o | output | 1 | Read strobe to the configuration memory |
| rd_addr_o | output | 8 | Read address |
| rd_data_i | input | 8 | Read data, valid one cycle after rd_en_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| id_pass_o | output | 1 | Identification check passed |
| blk_pass_o | output | 1 | Both region sums matched |
| fail_o | output | 1 | At least one check ran out of attempts |
| recover_o | output | 1 | One-cycle recovery request |
| recover_arg_o | output | 16 | Argument that goes with the recovery request |

## Verification
The bench builds the block with TRIES set to 3 and keeps every address, count and constant at its default. Running out of attempts therefore takes only a few hundred cycles, so every exhaustion path can be reached in each run: the identification check, the first region, the second region, and both checks together. The bench sweeps ten patterns of identification digits and rebalances the first region's filler bytes each time, so the region constants still hold. It also covers digit bytes below ASCII zero, which make the sum wrap, the shortcut reference word, and a start request made while busy. For every run it compares the full read-address sequence with a list computed in the bench.

// File: rtl/cfgchk_pkg.sv
package cfgchk_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_BEGIN,
    S_ISSUE,
    S_CAPT,
    S_EVAL
  } state_e;

  typedef enum logic [1:0] {
    STG_ID,
    STG_RA,
    STG_RB
  } stage_e;
endpackage

// File: rtl/cfgchk_plan.sv
module cfgchk_plan
  import cfgchk_pkg::*;
#(
  parameter int          AW      = 8,
  parameter int          SW      = 16,
  parameter int          IW      = 6,
  parameter int          ID_BASE = 'h0A,
  parameter int          ID_CNT  = 5,
  parameter int          ID_STEP = 2,
  parameter int          RA_BASE = 'h06,
  parameter int          RA_CNT  = 36,
  parameter logic [SW-1:0] RA_SUM = 16'h0706,
  parameter int          RB_BASE = 'h2C,
  parameter int          RB_CNT  = 36,
  parameter logic [SW-1:0] RB_SUM = 16'h0686
) (
  input  stage_e          stage_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [SW-1:0]   ref_i,
  output logic [AW-1:0]   addr_o,
  output logic            last_o,
  output logic [SW-1:0]   target_o,
  output logic            ascii_o
);
  always_comb begin
    unique case (stage_i)
      STG_ID: begin
        addr_o   = AW'(ID_BASE + int'(idx_i) * ID_STEP);
        last_o   = (idx_i == IW'(ID_CNT - 1));
        target_o = ref_i;
        ascii_o  = 1'b1;
      end
      STG_RA: begin
        addr_o   = AW'(RA_BASE + int'(idx_i));
        last_o   = (idx_i == IW'(RA_CNT - 1));
        target_o = RA_SUM;
        ascii_o  = 1'b0;
      end
      default: begin
        addr_o   = AW'(RB_BASE + int'(idx_i));
        last_o   = (idx_i == IW'(RB_CNT - 1));
        target_o = RB_SUM;
        ascii_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cfgchk_accum.sv
module cfgchk_accum #(
  parameter int DW   = 8,
  parameter int SW   = 16,
  parameter int BIAS = 'h30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic          bias_en_i,
  input  logic [DW-1:0] data_i,
  output logic [SW-1:0] sum_o
);
  logic [SW-1:0] term;

  // ASCII digits are de-biased; the sum wraps at SW bits
  always_comb term = {{(SW-DW){1'b0}}, data_i} - (bias_en_i ? SW'(BIAS) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_o <= '0;
    else if (clr_i)   sum_o <= '0;
    else if (add_i)   sum_o <= sum_o + term;
  end

  a_r8_no_clr_with_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && add_i));
endmodule

// File: rtl/cfgchk_retry.sv
module cfgchk_retry #(
  parameter int TRIES = 20,
  localparam int TW   = $clog2(TRIES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= TW'(TRIES);
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == TW'(1));

  a_r7_dec_not_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q > TW'(1)));
endmodule

// File: rtl/cfg_integrity_chk.sv
module cfg_integrity_chk
  import cfgchk_pkg::*;
#(
  parameter int            AW          = 8,
  parameter int            DW          = 8,
  parameter int            SW          = 16,
  parameter int            TRIES       = 20,
  parameter int            ID_BASE     = 'h0A,
  parameter int            ID_CNT      = 5,
  parameter int            ID_STEP     = 2,
  parameter int            ID_BIAS     = 'h30,
  parameter logic [SW-1:0] ID_MAGIC    = 16'h021C,
  parameter int            RA_BASE     = 'h06,
  parameter int            RA_CNT      = 36,
  parameter logic [SW-1:0] RA_SUM      = 16'h0706,
  parameter int            RB_BASE     = 'h2C,
  parameter int            RB_CNT      = 36,
  parameter logic [SW-1:0] RB_SUM      = 16'h0686,
  parameter logic [SW-1:0] RECOVER_ARG = 16'd100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] ref_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          id_pass_o,
  output logic          blk_pass_o,
  output logic          fail_o,
  output logic          recover_o,
  output logic [SW-1:0] recover_arg_o
);
  localparam int MAX_AB = (RA_CNT > RB_CNT) ? RA_CNT : RB_CNT;
  localparam int MAXC   = (ID_CNT > MAX_AB) ? ID_CNT : MAX_AB;
  localparam int IW     = $clog2(MAXC + 1);

  state_e        state_q;
  stage_e        stage_q;
  logic [IW-1:0] idx_q;
  logic [SW-1:0] sum, target;
  logic          last_byte, ascii, tries_last;
  logic          eval_ok, magic_hit, leave_id, tries_load, tries_dec;

  cfgchk_plan #(
    .AW(AW), .SW(SW), .IW(IW),
    .ID_BASE(ID_BASE), .ID_CNT(ID_CNT), .ID_STEP(ID_STEP),
    .RA_BASE(RA_BASE), .RA_CNT(RA_CNT), .RA_SUM(RA_SUM),
    .RB_BASE(RB_BASE), .RB_CNT(RB_CNT), .RB_SUM(RB_SUM)
  ) u_plan (
    .stage_i(stage_q), .idx_i(idx_q), .ref_i(ref_i),
    .addr_o(rd_addr_o), .last_o(last_byte), .target_o(target), .ascii_o(ascii)
  );

  cfgchk_accum #(.DW(DW), .SW(SW), .BIAS(ID_BIAS)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state_q == S_BEGIN), .add_i(state_q == S_CAPT),
    .bias_en_i(ascii), .data_i(rd_data_i), .sum_o(sum)
  );

  cfgchk_retry #(.TRIES(TRIES)) u_try (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(tries_load), .dec_i(tries_dec), .last_o(tries_last)
  );

  always_comb begin
    eval_ok    = (sum == target);
    magic_hit  = (state_q == S_BEGIN) && (stage_q == STG_ID) && (ref_i == ID_MAGIC);
    leave_id   = magic_hit ||
                 ((state_q == S_EVAL) && (stage_q == STG_ID) && (eval_ok || tries_last));
    tries_load = ((state_q == S_IDLE) && start_i) || leave_id;
    tries_dec  = (state_q == S_EVAL) && !eval_ok && !tries_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      stage_q    <= STG_ID;
      idx_q      <= '0;
      id_pass_o  <= 1'b0;
      blk_pass_o <= 1'b0;
      fail_o     <= 1'b0;
      done_o     <= 1'b0;
      recover_o  <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      recover_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          id_pass_o  <= 1'b0;
          blk_pass_o <= 1'b0;
          fail_o     <= 1'b0;
          stage_q    <= STG_ID;
          state_q    <= S_BEGIN;
        end
        S_BEGIN: begin
          idx_q <= '0;
          if (magic_hit) begin
            id_pass_o <= 1'b1;
            stage_q   <= STG_RA;
          end else begin
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: state_q <= S_CAPT;
        S_CAPT: begin
          if (last_byte) state_q <= S_EVAL;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_ISSUE;
          end
        end
        S_EVAL: begin
          state_q <= S_BEGIN;
          if (stage_q == STG_ID) begin
            if (eval_ok) id_pass_o <= 1'b1;
            else if (tries_last) begin
              fail_o    <= 1'b1;
              recover_o <= 1'b1;
            end
            if (eval_ok || tries_last) stage_q <= STG_RA;
          end else if (eval_ok && stage_q == STG_RA) begin
            stage_q <= STG_RB;
          end else if (eval_ok) begin
            blk_pass_o <= 1'b1;
            done_o     <= 1'b1;
            state_q    <= S_IDLE;
          end else if (tries_last) begin
            fail_o    <= 1'b1;
            recover_o <= 1'b1;
            done_o    <= 1'b1;
            state_q   <= S_IDLE;
          end else begin
            stage_q <= STG_RA;  // block attempt restarts at the first region
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_en_o       = (state_q == S_ISSUE);
  assign busy_o        = (state_q != S_IDLE);
  assign recover_arg_o = RECOVER_ARG;

  a_r8_read_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_busy_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r7_recover_with_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |-> fail_o);
  a_r7_recover_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o |=> !recover_o);
endmodule

// File: tb/sim_cfg_integrity_chk.sv
module sim_cfg_integrity_chk;
  localparam int TRIES = 3;
  localparam int MAGIC = 'h021C;
  localparam int LOGN  = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] ref_w = '0;
  logic        rd_en, busy, done, id_pass, blk_pass, fail, recover;
  logic [7:0]  rd_addr, rd_q;
  logic [15:0] recover_arg;

  int errors = 0, checks = 0;
  logic [7:0] mem [256];
  int rd_log [LOGN];
  int exp_a  [LOGN];
  int rd_n = 0, rec_n = 0, done_n = 0, b2b = 0, arg_bad = 0;
  logic prev_rd = 1'b0;

  always #10 clk = ~clk;

  cfg_integrity_chk #(.TRIES(TRIES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ref_i(ref_w),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_q),
    .busy_o(busy), .done_o(done), .id_pass_o(id_pass), .blk_pass_o(blk_pass),
    .fail_o(fail), .recover_o(recover), .recover_arg_o(recover_arg)
  );

  always @(posedge clk) begin
    if (rd_en) begin
      rd_q <= mem[rd_addr];
      if (rd_n < LOGN) rd_log[rd_n] = int'(rd_addr);
      rd_n = rd_n + 1;
    end
    if (rd_en && prev_rd) b2b = b2b + 1;
    prev_rd = rd_en;
    if (recover) begin
      rec_n = rec_n + 1;
      if (recover_arg != 16'd100) arg_bad = arg_bad + 1;
    end
    if (done) done_n = done_n + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // raw=1 puts bytes below ASCII zero on the identification addresses
  task automatic fill_mem(input int seed, input bit raw, input bit ca, input bit cb,
                          output int idsum);
    int s, f;
    for (int a = 0; a < 256; a++) mem[a] = 8'hA5;
    s = 0; idsum = 0;
    for (int k = 0; k < 5; k++) begin
      mem['h0A + 2*k] = raw ? 8'(k) : 8'('h30 + (seed + 3*k) % 10);
      s += int'(mem['h0A + 2*k]);
      idsum += int'(mem['h0A + 2*k]) - 'h30;
    end
    idsum = idsum & 'hFFFF;
    f = ('h0706 - s) / 31;
    for (int a = 'h06; a < 'h29; a++)
      if (!(a >= 'h0A && a <= 'h12 && a % 2 == 0)) mem[a] = 8'(f);
    mem['h29] = 8'('h0706 - s - 30*f);
    for (int a = 'h2C; a < 'h4F; a++) mem[a] = 8'd46;
    mem['h4F] = 8'('h0686 - 35*46);
    if (ca) mem['h07] = mem['h07] + 8'd1;
    if (cb) mem['h30] = mem['h30] + 8'd1;
  endtask

  // rsel: 0 matching ref, 1 wrong ref, 2 shortcut ref
  task automatic run_case(input string tag, input int seed, input bit raw, input int rsel,
                          input bit ca, input bit cb, input bit poke);
    int idsum, n, rd0, rec0, dn0, t, id_att, blk_att, mism, exp_rec;
    bit id_ok, blk_ok;
    fill_mem(seed, raw, ca, cb, idsum);
    id_ok  = (rsel != 1);
    blk_ok = !ca && !cb;
    n = 0;
    if (rsel != 2) begin
      id_att = id_ok ? 1 : TRIES;
      for (int r = 0; r < id_att; r++)
        for (int k = 0; k < 5; k++) begin exp_a[n] = 'h0A + 2*k; n++; end
    end
    blk_att = blk_ok ? 1 : TRIES;
    for (int r = 0; r < blk_att; r++) begin
      for (int a = 'h06; a <= 'h29; a++) begin exp_a[n] = a; n++; end
      if (!ca) for (int a = 'h2C; a <= 'h4F; a++) begin exp_a[n] = a; n++; end
    end
    exp_rec = (id_ok ? 0 : 1) + (blk_ok ? 0 : 1);
    rd0 = rd_n; rec0 = rec_n; dn0 = done_n;

    @(negedge clk);
    ref_w = (rsel == 0) ? 16'(idsum) : (rsel == 1) ? 16'(idsum + 1) : 16'(MAGIC);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 busy after start"}, int'(busy), 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
    chk({tag, " R9 done seen"}, int'(done === 1'b1), 1);
    chk({tag, " R9 idle at done"}, int'(busy), 0);
    chk({tag, " R4 id pass"}, int'(id_pass), int'(id_ok));
    chk({tag, " R6 blk pass"}, int'(blk_pass), int'(blk_ok));
    chk({tag, " R7 fail flag"}, int'(fail), int'(!(id_ok && blk_ok)));
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, int'(done), 0);
    chk({tag, " R9 flags held"}, int'({id_pass, blk_pass}), int'({id_ok, blk_ok}));
    chk({tag, " R2 single done"}, done_n - dn0, 1);
    chk({tag, " R7 recover count"}, rec_n - rec0, exp_rec);
    chk({tag, " R5 R6 read count"}, rd_n - rd0, n);
    mism = 0;
    if (rd_n - rd0 == n && rd_n <= LOGN)
      for (int i = 0; i < n; i++) if (rd_log[rd0 + i] != exp_a[i]) mism++;
    chk({tag, " R4 R5 R6 address order"}, mism, 0);
    if (rd_n > LOGN - 400) begin rd_n = 0; end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 outputs in reset", int'({done, rd_en, recover, id_pass, blk_pass, fail}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'({busy, done, rd_en, recover, id_pass, blk_pass, fail}), 0);

    for (int s = 0; s < 10; s++) run_case("sweep R4 R5 R6", s, 1'b0, 0, 1'b0, 1'b0, 1'b0);
    run_case("shortcut R3", 4, 1'b0, 2, 1'b0, 1'b0, 1'b0);
    run_case("id exhaust R7", 2, 1'b0, 1, 1'b0, 1'b0, 1'b0);
    run_case("region A bad R5", 1, 1'b0, 0, 1'b1, 1'b0, 1'b0);
    run_case("region B bad R6", 7, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    run_case("both bad R7", 3, 1'b0, 1, 1'b0, 1'b1, 1'b0);
    run_case("wrap R10", 0, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    run_case("wrap wrong R10", 0, 1'b1, 1, 1'b0, 1'b0, 1'b0);
    run_case("start while busy R2", 5, 1'b0, 0, 1'b0, 1'b0, 1'b1);
    run_case("start while busy fail R2", 6, 1'b0, 1, 1'b1, 1'b0, 1'b1);

    chk("R8 no back-to-back reads", b2b, 0);
    chk("R7 recover argument 100", arg_bad, 0);
    summary();
  end
endmodule